// File: doc/BRIEF.md
# Hot-Plug Detect Filter with Interrupt Events

This block cleans up the asynchronous hot-plug detect line of a display transmitter and turns its accepted level changes into interrupt events. The raw line is first brought into the clock domain by a two-flop synchronizer. It then passes through two width filters in series. The first is a short glitch rejector with a 4-bit width. The second is a long validity filter whose 12-bit width is scaled by 1024. The second filter's output is the filtered hot-plug level.

Every accepted rising or falling change of the filtered level sets a pending interrupt bit. A third source is the rising edge of a core interrupt input, which comes from the same clock domain. Software uses a small synchronous register port to:
- set the two filter widths,
- enable each source,
- read the pending bits or force them set,
- clear pending bits through a separate register,
- read the filtered level.

The single interrupt output is high while any enabled source is pending.

Top module: `hpd_event_filter`

## Requirements
- R1: After reset the filtered level, all pending bits, the enable mask, both filter widths and `irqOut` are 0.
- R2: With glitch width N (configuration bits [3:0]) and validity width 0, a high pulse on `hpdRaw` lasting N clock cycles or less leaves the filtered level unchanged. A pulse lasting N+1 cycles raises it.
- R3: With validity width M (configuration bits [19:8]), a level change that has passed the glitch stage is accepted only once it has lasted more than M*1024 cycles. With N=0 and M=1, a held change on `hpdRaw` appears in the filtered level after the 1028th clock edge and not earlier.
- R4: Both widths at 0 mean no filtering. A change on `hpdRaw` appears in the filtered level after the fourth clock edge and sets its pending bit after the fifth. With glitch width N it appears after edge N+4.
- R5: An accepted rise of the filtered level sets pending bit 1, and an accepted fall sets pending bit 2.
- R6: A rising edge of `coreIrq` sets pending bit 0. Holding `coreIrq` high sets the bit only once.
- R7: Writing the status register (address 2) sets every pending bit written as 1 and leaves the bits written as 0 alone. Reads of address 2 return the pending bits in [2:0].
- R8: Writing the clear register (address 3) clears every pending bit written as 1 and leaves the bits written as 0 alone.
- R9: If a set and a clear reach the same pending bit in the same cycle, the bit ends up set.
- R10: `irqOut` is 1 exactly when some pending bit has its enable bit set in the mask register (address 1, bits [2:0], 1 enables).
- R11: Address 0 reads back the configuration fields and address 1 reads back the mask. Address 4 bit 0 returns the filtered level. Addresses 3, 5, 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hpdRaw | input | 1 | Unsynchronized hot-plug detect line |
| coreIrq | input | 1 | Core interrupt level, same clock domain |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from `regAddr` |
| irqOut | output | 1 | OR of enabled pending sources |

## Verification
A miscounting width counter shows up at the level register as an acceptance one or more cycles early or late. The bench checks the exact edge on which the level flips, for several glitch widths and for the 1024-scaled width, so a miscount is seen within one cycle of the expected change. A wrong pending-bit update (a lost event, a clear that beats a set, or an edge counted twice on a held core interrupt) appears in the status read and on `irqOut` one edge after the event. The sweeps of pulse width against glitch width separate the pulses that are rejected from those that are accepted at the boundary N versus N+1.

// File: rtl/hpf_pkg.sv
package hpf_pkg;
  localparam int HPF_GLITCH_W   = 4;
  localparam int HPF_VALID_W    = 12;
  localparam int HPF_SCALE_LOG2 = 10;
  localparam int HPF_NSRC       = 3;
  localparam int HPF_ADDR_W     = 3;
  localparam int HPF_DATA_W     = 32;
  localparam int HPF_N_LSB      = 0;
  localparam int HPF_M_LSB      = 8;

  typedef enum logic [HPF_ADDR_W-1:0] {
    ADDR_CFG   = 3'd0,
    ADDR_MASK  = 3'd1,
    ADDR_STAT  = 3'd2,
    ADDR_CLR   = 3'd3,
    ADDR_LEVEL = 3'd4
  } hpfAddr_e;

  // control -> datapath
  typedef struct packed {
    logic [HPF_GLITCH_W-1:0] glitchN;
    logic [HPF_VALID_W-1:0]  validM;
  } hpfCfg_t;

  // datapath -> control, one pulse per accepted event
  typedef struct packed {
    logic hpdFall;
    logic hpdRise;
    logic coreRise;
  } hpfEvt_t;
endpackage

// File: rtl/hpf_width_filter.sv
module hpf_width_filter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             din,
  input  logic [CNT_W-1:0] limit,
  output logic             dout,
  output logic             changeP
);
  logic [CNT_W-1:0] runCnt;
  logic             differ;
  logic             accept;

  assign differ = (din != dout);
  assign accept = differ && (runCnt >= limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dout    <= 1'b0;
      runCnt  <= '0;
      changeP <= 1'b0;
    end else begin
      changeP <= accept;
      if (!differ) begin
        runCnt <= '0;
      end else if (accept) begin
        dout   <= din;
        runCnt <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  // R2/R3: the output only ever moves to the value the input held one edge earlier
  p_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dout != $past(dout)) |-> (dout == $past(din)));

  // R5: a change pulse accompanies every output toggle
  p_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    changeP |-> (dout != $past(dout)));
endmodule

// File: rtl/hpf_datapath.sv
module hpf_datapath
  import hpf_pkg::*;
#(
  parameter int GLITCH_W   = HPF_GLITCH_W,
  parameter int VALID_W    = HPF_VALID_W,
  parameter int SCALE_LOG2 = HPF_SCALE_LOG2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    hpdRaw,
  input  logic    coreIrq,
  input  hpfCfg_t cfg,
  output logic    hpdLevel,
  output hpfEvt_t evt
);
  localparam int LONG_W = VALID_W + SCALE_LOG2;

  logic [1:0]        syncQ;
  logic              glitchOut;
  logic              glitchChg;
  logic              levelChg;
  logic              coreQ;
  logic [LONG_W-1:0] longLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      coreQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], hpdRaw};
      coreQ <= coreIrq;
    end
  end

  assign longLimit = {cfg.validM[VALID_W-1:0], {SCALE_LOG2{1'b0}}};

  hpf_width_filter #(.CNT_W(GLITCH_W)) uGlitch (
    .clk(clk), .rstN(rstN), .din(syncQ[1]), .limit(cfg.glitchN[GLITCH_W-1:0]),
    .dout(glitchOut), .changeP(glitchChg)
  );

  hpf_width_filter #(.CNT_W(LONG_W)) uValid (
    .clk(clk), .rstN(rstN), .din(glitchOut), .limit(longLimit),
    .dout(hpdLevel), .changeP(levelChg)
  );

  always_comb begin
    evt.coreRise = coreIrq && !coreQ;
    evt.hpdRise  = levelChg && hpdLevel;
    evt.hpdFall  = levelChg && !hpdLevel;
  end

  // R5: rise and fall events never coincide
  p_evt_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({evt.hpdRise, evt.hpdFall}));

  // R4: with zero glitch width the glitch stage follows the synchronizer in one edge
  p_zero_glitch_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.glitchN == '0 && glitchOut != syncQ[1]) |=> (glitchOut == $past(syncQ[1])));

  // R6: a held core interrupt produces no second edge
  p_core_once_r6: assert property (@(posedge clk) disable iff (!rstN)
    evt.coreRise |=> !evt.coreRise);

  logic unusedChg;
  assign unusedChg = glitchChg;
endmodule

// File: rtl/hpf_control.sv
module hpf_control
  import hpf_pkg::*;
#(
  parameter int ADDR_W = HPF_ADDR_W,
  parameter int DATA_W = HPF_DATA_W,
  parameter int NSRC   = HPF_NSRC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              hpdLevel,
  input  hpfEvt_t           evt,
  output hpfCfg_t           cfg,
  output logic              irqOut
);
  logic [NSRC-1:0] pendQ;
  logic [NSRC-1:0] maskQ;
  logic [NSRC-1:0] swSet;
  logic [NSRC-1:0] swClr;
  logic [NSRC-1:0] hwSet;
  logic [NSRC-1:0] setVec;
  logic            wrCfg, wrMask, wrStat, wrClr;

  always_comb begin
    wrCfg  = regWrEn && (regAddr == ADDR_CFG);
    wrMask = regWrEn && (regAddr == ADDR_MASK);
    wrStat = regWrEn && (regAddr == ADDR_STAT);
    wrClr  = regWrEn && (regAddr == ADDR_CLR);
    swSet  = wrStat ? regWrData[NSRC-1:0] : '0;
    swClr  = wrClr  ? regWrData[NSRC-1:0] : '0;
    hwSet  = {evt.hpdFall, evt.hpdRise, evt.coreRise};
    setVec = swSet | hwSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      maskQ <= '0;
      cfg   <= '0;
    end else begin
      pendQ <= (pendQ & ~swClr) | setVec;   // set wins over clear
      if (wrMask) maskQ <= regWrData[NSRC-1:0];
      if (wrCfg) begin
        cfg.glitchN <= regWrData[HPF_N_LSB +: HPF_GLITCH_W];
        cfg.validM  <= regWrData[HPF_M_LSB +: HPF_VALID_W];
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CFG: begin
        regRdData[HPF_N_LSB +: HPF_GLITCH_W] = cfg.glitchN;
        regRdData[HPF_M_LSB +: HPF_VALID_W]  = cfg.validM;
      end
      ADDR_MASK:  regRdData[NSRC-1:0] = maskQ;
      ADDR_STAT:  regRdData[NSRC-1:0] = pendQ;
      ADDR_LEVEL: regRdData[0]        = hpdLevel;
      default:    regRdData           = '0;
    endcase
  end

  assign irqOut = |(pendQ & maskQ);

  // R9: any bit set in a cycle is pending after the edge, whatever the clear
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|setVec) |=> ((pendQ & $past(setVec)) == $past(setVec)));

  // R8: a clear with no competing set leaves the bit low
  p_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrClr |=> ((pendQ & $past(swClr & ~setVec)) == '0));

  // R10: an empty mask keeps the interrupt quiet
  p_mask_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |-> !irqOut);

  // R7: a pending bit only rises through a set source
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rstN)
    ((pendQ & ~$past(pendQ)) & ~$past(setVec)) == '0);
endmodule

// File: rtl/hpd_event_filter.sv
module hpd_event_filter
  import hpf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  hpdRaw,
  input  logic                  coreIrq,
  input  logic                  regWrEn,
  input  logic [HPF_ADDR_W-1:0] regAddr,
  input  logic [HPF_DATA_W-1:0] regWrData,
  output logic [HPF_DATA_W-1:0] regRdData,
  output logic                  irqOut
);
  hpfCfg_t cfg;
  hpfEvt_t evt;
  logic    hpdLevel;

  hpf_datapath uDp (
    .clk(clk), .rstN(rstN), .hpdRaw(hpdRaw), .coreIrq(coreIrq),
    .cfg(cfg), .hpdLevel(hpdLevel), .evt(evt)
  );

  hpf_control uCtl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .hpdLevel(hpdLevel),
    .evt(evt), .cfg(cfg), .irqOut(irqOut)
  );
endmodule

// File: tb/tb_hpd_event_filter.sv
module tb_hpd_event_filter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hpdRaw = 1'b0;
  logic        coreIrq = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #4 clk = ~clk;   // 125 MHz

  hpd_event_filter dut (
    .clk(clk), .rstN(rstN), .hpdRaw(hpdRaw), .coreIrq(coreIrq),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  // write occupies exactly one posedge; returns at the following negedge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  // called at a negedge; combinational read
  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1: reset state
    rd(3'd4, d); chk("R1 level", d, 0);
    rd(3'd2, d); chk("R1 pending", d, 0);
    rd(3'd1, d); chk("R1 mask", d, 0);
    rd(3'd0, d); chk("R1 cfg", d, 0);
    chk("R1 irq", {31'd0, irqOut}, 0);

    // R4: exact latency per glitch width, validity width 0
    for (int n = 0; n < 4; n++) begin
      wr(3'd0, n);
      idle(4);
      hpdRaw = 1'b1;
      repeat (n + 3) @(posedge clk);
      @(negedge clk); rd(3'd4, d); chk($sformatf("R4 early n=%0d", n), d, 0);
      @(negedge clk); rd(3'd4, d); chk($sformatf("R4 level n=%0d", n), d, 1);
      if (n == 0) begin
        @(negedge clk); rd(3'd2, d); chk("R4 R5 rise pend", d, 32'h2);
      end
      hpdRaw = 1'b0;
      idle(n + 8);
      rd(3'd4, d); chk($sformatf("R5 fell n=%0d", n), d, 0);
      rd(3'd2, d); chk($sformatf("R5 both pend n=%0d", n), d, 32'h6);
      wr(3'd3, 32'h7);
      rd(3'd2, d); chk("R8 cleared", d, 0);
    end

    // R2: pulse width sweep against glitch width
    for (int n = 0; n < 4; n++) begin
      wr(3'd0, n);
      for (int w = 1; w <= n + 2; w++) begin
        @(negedge clk); hpdRaw = 1'b1;
        repeat (w) @(negedge clk);
        hpdRaw = 1'b0;
        idle(n + 12);
        rd(3'd2, d);
        chk($sformatf("R2 n=%0d w=%0d", n, w), d, (w > n) ? 32'h6 : 32'h0);
        wr(3'd3, 32'h7);
      end
    end

    // R3: validity width M=1 (1024 cycles), glitch 0
    wr(3'd0, 32'h100);
    rd(3'd0, d); chk("R11 cfg readback", d, 32'h100);
    idle(2);
    hpdRaw = 1'b1;
    repeat (1027) @(posedge clk);
    @(negedge clk); rd(3'd4, d); chk("R3 early", d, 0);
    @(negedge clk); rd(3'd4, d); chk("R3 level", d, 1);
    hpdRaw = 1'b0;
    idle(1100);
    wr(3'd3, 32'h7);
    for (int w = 1024; w <= 1025; w++) begin
      @(negedge clk); hpdRaw = 1'b1;
      repeat (w) @(negedge clk);
      hpdRaw = 1'b0;
      idle(1100);
      rd(3'd2, d);
      chk($sformatf("R3 w=%0d", w), d, (w > 1024) ? 32'h6 : 32'h0);
      wr(3'd3, 32'h7);
    end
    wr(3'd0, 0);

    // R6: core rising edge, held high
    @(negedge clk); coreIrq = 1'b1;
    @(negedge clk); rd(3'd2, d); chk("R6 core set", d, 32'h1);
    wr(3'd3, 32'h1);
    idle(5);
    rd(3'd2, d); chk("R6 held no reset", d, 0);
    coreIrq = 1'b0;
    idle(2);

    // R9: core edge and clear of the same bit in one cycle
    wr(3'd2, 32'h1);
    @(negedge clk);
    coreIrq = 1'b1; regWrEn = 1'b1; regAddr = 3'd3; regWrData = 32'h1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
    rd(3'd2, d); chk("R9 set wins", d, 32'h1);
    coreIrq = 1'b0;
    wr(3'd3, 32'h7);

    // R7 / R8: partial set and clear
    wr(3'd2, 32'h5);
    rd(3'd2, d); chk("R7 set 5", d, 32'h5);
    wr(3'd2, 32'h0);
    rd(3'd2, d); chk("R7 zero write", d, 32'h5);
    wr(3'd3, 32'h4);
    rd(3'd2, d); chk("R8 clear 4", d, 32'h1);
    wr(3'd3, 32'h0);
    rd(3'd2, d); chk("R8 zero clear", d, 32'h1);
    wr(3'd3, 32'h7);

    // R10: mask sweep over all pending/mask pairs
    for (int p = 0; p < 8; p++) begin
      for (int m = 0; m < 8; m++) begin
        wr(3'd3, 32'h7);
        wr(3'd2, p);
        wr(3'd1, m);
        chk($sformatf("R10 p=%0d m=%0d", p, m), {31'd0, irqOut}, ((p & m) != 0) ? 1 : 0);
      end
    end
    rd(3'd1, d); chk("R11 mask readback", d, 32'h7);

    // R11: unmapped and write-only addresses
    for (int a = 5; a < 8; a++) begin
      rd(a[2:0], d); chk($sformatf("R11 addr %0d", a), d, 0);
    end
    rd(3'd3, d); chk("R11 clear reads 0", d, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule